// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and offers a single pending flag to a processor. Each line is captured either on a rising edge or as a level, as chosen per line. The captured requests are gated by a mask register. A rotating priority base then decides which request wins. A request is raised only when it outranks everything that is already in service. An acknowledge strobe moves the winning line into service and returns its vector, which is the programmed vector base plus the line number.

Software programs the block through three byte addresses. Address 0 is the command port. Address 1 is the data port. Address 2 holds the edge/level selection. A command-port write with bit 4 set starts an initialization sequence, which continues on the data port. Other command-port writes choose the readback register, arm a one-shot poll read, or issue end-of-interrupt and rotation commands. The `is_master` input chooses the write mask of the edge/level register. It also enables the special nested exclusion of line 2.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_pending` is low, and reads of address 0 (request register), address 1 (mask) and address 2 (edge/level register) all return 0x00.
- R2: A line whose edge/level bit is 0 sets its request bit one cycle after the input goes from low to high, measured against the sample taken in the previous cycle. A falling input never clears that bit, and an input held high does not set it again.
- R3: A line whose edge/level bit is 1 has a request bit equal to the input of the previous cycle, and an acknowledge does not clear it.
- R4: A write to address 2 stores the written byte ANDed with 0xF8 when `is_master` is 1, or with 0xDE when it is 0.
- R5: Line (k + base) mod 8 has priority k, and 0 is the highest. Masked lines take no part. `int_pending` is high only when the best unmasked request has a strictly higher priority than the best in-service bit.
- R6: When `is_master` is 1 and special nesting is on, in-service bit 2 is left out of the comparison in R5.
- R7: A command-port write with bit 4 set clears mask, in-service, request, base, vector base, readback select, poll and all mode flags, and keeps bit 0 as "fourth word due". The next data-port writes are taken in this order: vector base (value AND 0xF8); a word with no effect; then, only if due, a mode word (bit 4 = special nesting, bit 1 = auto end-of-interrupt). After that, data-port writes load the mask.
- R8: An acknowledge while pending returns vector base + line. It sets that in-service bit and clears the request bit of an edge line. An acknowledge while not pending returns vector base + 7 and changes nothing.
- R9: With auto end-of-interrupt on, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is also set (command bits 7:5 = 4 sets it, 0 clears it), the base becomes line + 1.
- R10: Command bits 7:5 = 1 clear the highest-priority in-service bit. A value of 5 does the same and then sets the base to that line + 1.
- R11: Command bits 7:5 = 3 clear in-service bit wdata[2:0]. A value of 6 sets the base to wdata[2:0] + 1. A value of 7 does both for line wdata[2:0]. A value of 2 changes nothing.
- R12: A command-port write with bit 4 = 0 and bit 3 = 1 and bit 1 = 1 makes address 0 read back the in-service register (bit 0 = 1) or the request register (bit 0 = 0). Address 1 reads back the mask.
- R13: When bit 2 of that command is set, the next read of address 0 or 1 returns the pending line number and clears its request and in-service bits. If no line is pending, that read returns 7. Poll mode then turns itself off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 selects the master write mask and enables the special nesting exclusion |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (poll side effects occur on this edge) |
| addr | input | 2 | 0 command, 1 data, 2 edge/level register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ack | input | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Vector returned for an acknowledge in this cycle |
| int_pending | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is special nesting, because it needs three things at once. Line 2 must already be in service. The same line must be requested again. The unit must be a master whose initialization included the optional fourth word. The bench gets there with a directed sequence. It re-initializes with a mode word, acknowledges line 2, and then drops and raises that line again. It then checks that the request still wins, and that it stops winning once `is_master` goes low. Random traffic also issues initialization commands at random points. This leaves later data writes partway through the word sequence, so mode words, poll reads and acknowledges meet in orders that directed tests would not produce.

// File: rtl/prio_irq_pkg.sv
// Shared encodings of the interrupt controller: register addresses,
// initialization-word states and operation command codes.
package prio_irq_pkg;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

    typedef enum logic [1:0] {
        INIT_IDLE  = 2'd0,
        INIT_VBASE = 2'd1,
        INIT_SKIP  = 2'd2,
        INIT_MODE  = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        OC_ROT_OFF    = 3'd0,
        OC_EOI_NS     = 3'd1,
        OC_NOP        = 3'd2,
        OC_EOI_SP     = 3'd3,
        OC_ROT_ON     = 3'd4,
        OC_EOI_NS_ROT = 3'd5,
        OC_SET_BASE   = 3'd6,
        OC_EOI_SP_ROT = 3'd7
    } opcmd_e;

endpackage

// File: rtl/irq_capture.sv
// Request capture: holds the request register and the previous input
// sample. Level lines copy the input; edge lines set on a rising input.
// Assumes irq_in is already synchronous to clk.
module irq_capture #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] trig,
    input  logic [LINES-1:0] clr,
    input  logic             init_clr,
    output logic [LINES-1:0] irr
);

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] irr_q;
    logic [LINES-1:0] rise;

    // Rising-edge detect against the stored sample
    assign rise = irq_in & ~prev_q;

    // Request and previous-level registers
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            irr_q  <= ((trig & irq_in) | (~trig & (irr_q | rise))) & ~clr;
        end
    end

    assign irr = irr_q;

endmodule

// File: rtl/irq_prio_find.sv
// Priority search: returns the priority k of the first set bit at line
// (k + base) mod LINES, or LINES when the mask is empty.
// Assumes LINES is a power of two.
module irq_prio_find #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int PW = IDX_W + 1
) (
    input  logic [LINES-1:0] mask,
    input  logic [IDX_W-1:0] base,
    output logic [PW-1:0]    prio
);

    // Scan from lowest priority upward so the best match lands last
    always_comb begin
        prio = PW'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (mask[IDX_W'(k) + base]) prio = PW'(k);
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
// Register and command block: mask, in-service, priority base, vector
// base, mode flags, initialization-word sequencing, readback and poll,
// and acknowledge handling. Same-cycle precedence: write, then read,
// then acknowledge.
module irq_ctrl_regs
    import prio_irq_pkg::*;
#(
    parameter int LINES = 8,
    parameter logic [LINES-1:0] TRIG_MASK_MASTER = 8'hF8,
    parameter logic [LINES-1:0] TRIG_MASK_SLAVE  = 8'hDE,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [LINES-1:0] wdata,
    input  logic             ack,
    input  logic [LINES-1:0] irr,
    input  logic             pend,
    input  logic [IDX_W-1:0] pend_line,
    input  logic             isr_found,
    input  logic [IDX_W-1:0] isr_line,
    output logic [LINES-1:0] rdata,
    output logic [LINES-1:0] vector,
    output logic [LINES-1:0] imr,
    output logic [LINES-1:0] isr,
    output logic [LINES-1:0] trig,
    output logic [IDX_W-1:0] base,
    output logic             sfnm,
    output logic             aeoi,
    output logic             poll,
    output logic [LINES-1:0] irr_clr,
    output logic             init_clr
);

    localparam logic [LINES-1:0] VBASE_MASK = ~LINES'(LINES - 1);
    localparam logic [IDX_W-1:0] SPUR_LINE  = IDX_W'(LINES - 1);

    logic [LINES-1:0] imr_q, imr_n, isr_q, isr_n, trig_q, trig_n;
    logic [LINES-1:0] vbase_q, vbase_n;
    logic [IDX_W-1:0] base_q, base_n;
    logic             rdsel_q, rdsel_n, poll_q, poll_n, need4_q, need4_n;
    logic             aeoi_q, aeoi_n, rot_q, rot_n, sfnm_q, sfnm_n;
    init_st_e         ist_q, ist_n;
    logic [IDX_W-1:0] wline;
    logic [IDX_W-1:0] out_line;

    assign wline = wdata[IDX_W-1:0];

    // Next-state decode for writes, poll reads and acknowledges
    always_comb begin
        imr_n    = imr_q;
        isr_n    = isr_q;
        trig_n   = trig_q;
        vbase_n  = vbase_q;
        base_n   = base_q;
        rdsel_n  = rdsel_q;
        poll_n   = poll_q;
        need4_n  = need4_q;
        aeoi_n   = aeoi_q;
        rot_n    = rot_q;
        sfnm_n   = sfnm_q;
        ist_n    = ist_q;
        irr_clr  = '0;
        init_clr = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_CMD: begin
                    if (wdata[4]) begin
                        imr_n    = '0;
                        isr_n    = '0;
                        vbase_n  = '0;
                        base_n   = '0;
                        rdsel_n  = 1'b0;
                        poll_n   = 1'b0;
                        aeoi_n   = 1'b0;
                        rot_n    = 1'b0;
                        sfnm_n   = 1'b0;
                        need4_n  = wdata[0];
                        ist_n    = INIT_VBASE;
                        init_clr = 1'b1;
                    end else if (wdata[3]) begin
                        if (wdata[2]) poll_n = 1'b1;
                        if (wdata[1]) rdsel_n = wdata[0];
                    end else begin
                        case (opcmd_e'(wdata[7:5]))
                            OC_ROT_OFF, OC_ROT_ON: rot_n = wdata[7];
                            OC_EOI_NS, OC_EOI_NS_ROT: begin
                                if (isr_found) begin
                                    isr_n[isr_line] = 1'b0;
                                    if (wdata[7]) base_n = isr_line + IDX_W'(1);
                                end
                            end
                            OC_EOI_SP: isr_n[wline] = 1'b0;
                            OC_SET_BASE: base_n = wline + IDX_W'(1);
                            OC_EOI_SP_ROT: begin
                                isr_n[wline] = 1'b0;
                                base_n = wline + IDX_W'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                ADDR_DATA: begin
                    case (ist_q)
                        INIT_IDLE: imr_n = wdata;
                        INIT_VBASE: begin
                            vbase_n = wdata & VBASE_MASK;
                            ist_n   = INIT_SKIP;
                        end
                        INIT_SKIP: ist_n = need4_q ? INIT_MODE : INIT_IDLE;
                        INIT_MODE: begin
                            sfnm_n = wdata[4];
                            aeoi_n = wdata[1];
                            ist_n  = INIT_IDLE;
                        end
                        default: ist_n = INIT_IDLE;
                    endcase
                end
                ADDR_TRIG: trig_n = wdata & (is_master ? TRIG_MASK_MASTER : TRIG_MASK_SLAVE);
                default: ;
            endcase
        end else if (rd_en) begin
            if (poll_q && !addr[1]) begin
                poll_n = 1'b0;
                if (pend) begin
                    irr_clr[pend_line] = 1'b1;
                    isr_n[pend_line]   = 1'b0;
                end
            end
        end else if (ack && pend) begin
            if (!trig_q[pend_line]) irr_clr[pend_line] = 1'b1;
            if (aeoi_q) begin
                if (rot_q) base_n = pend_line + IDX_W'(1);
            end else begin
                isr_n[pend_line] = 1'b1;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q   <= '0;
            isr_q   <= '0;
            trig_q  <= '0;
            vbase_q <= '0;
            base_q  <= '0;
            rdsel_q <= 1'b0;
            poll_q  <= 1'b0;
            need4_q <= 1'b0;
            aeoi_q  <= 1'b0;
            rot_q   <= 1'b0;
            sfnm_q  <= 1'b0;
            ist_q   <= INIT_IDLE;
        end else begin
            imr_q   <= imr_n;
            isr_q   <= isr_n;
            trig_q  <= trig_n;
            vbase_q <= vbase_n;
            base_q  <= base_n;
            rdsel_q <= rdsel_n;
            poll_q  <= poll_n;
            need4_q <= need4_n;
            aeoi_q  <= aeoi_n;
            rot_q   <= rot_n;
            sfnm_q  <= sfnm_n;
            ist_q   <= ist_n;
        end
    end

    // Line reported to poll reads and acknowledges
    assign out_line = pend ? pend_line : SPUR_LINE;

    // Readback multiplexer
    always_comb begin
        if (poll_q && !addr[1]) begin
            rdata = {{(LINES-IDX_W){1'b0}}, out_line};
        end else begin
            case (addr)
                ADDR_CMD:  rdata = rdsel_q ? isr_q : irr;
                ADDR_DATA: rdata = imr_q;
                ADDR_TRIG: rdata = trig_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign vector = vbase_q | {{(LINES-IDX_W){1'b0}}, out_line};
    assign imr    = imr_q;
    assign isr    = isr_q;
    assign trig   = trig_q;
    assign base   = base_q;
    assign sfnm   = sfnm_q;
    assign aeoi   = aeoi_q;
    assign poll   = poll_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the interrupt controller: request capture, three priority
// searches (request, in-service for the comparison, full in-service for
// end-of-interrupt) and the register block. int_pending and vector are
// combinational from registered state.
module prio_irq_ctrl #(
    parameter int LINES = 8,
    parameter int CASCADE_LINE = 2,
    parameter logic [LINES-1:0] TRIG_MASK_MASTER = 8'hF8,
    parameter logic [LINES-1:0] TRIG_MASK_SLAVE  = 8'hDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic [LINES-1:0] irq_in,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic             ack,
    output logic [LINES-1:0] vector,
    output logic             int_pending
);

    localparam int IDX_W = $clog2(LINES);
    localparam int PW = IDX_W + 1;
    localparam int N_FIND = 3;
    localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;

    logic [LINES-1:0] irr, imr, isr, trig, irr_clr;
    logic [IDX_W-1:0] base;
    logic             sfnm, aeoi, poll, init_clr;
    logic [LINES-1:0] find_mask [N_FIND];
    logic [PW-1:0]    find_prio [N_FIND];
    logic             pend;
    logic [IDX_W-1:0] pend_line, isr_line;
    logic             isr_found;

    irq_capture #(.LINES(LINES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .trig     (trig),
        .clr      (irr_clr),
        .init_clr (init_clr),
        .irr      (irr)
    );

    // Search inputs: unmasked requests, nested-adjusted and full in-service
    assign find_mask[0] = irr & ~imr;
    assign find_mask[1] = isr & ~((sfnm && is_master) ? CASC_BIT : '0);
    assign find_mask[2] = isr;

    for (genvar g = 0; g < N_FIND; g++) begin : g_find
        irq_prio_find #(.LINES(LINES)) u_find (
            .mask (find_mask[g]),
            .base (base),
            .prio (find_prio[g])
        );
    end

    // Request wins only when strictly ahead of current service level
    assign pend      = (find_prio[0] != PW'(LINES)) && (find_prio[0] < find_prio[1]);
    assign pend_line = find_prio[0][IDX_W-1:0] + base;
    assign isr_found = (find_prio[2] != PW'(LINES));
    assign isr_line  = find_prio[2][IDX_W-1:0] + base;

    irq_ctrl_regs #(
        .LINES            (LINES),
        .TRIG_MASK_MASTER (TRIG_MASK_MASTER),
        .TRIG_MASK_SLAVE  (TRIG_MASK_SLAVE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .ack       (ack),
        .irr       (irr),
        .pend      (pend),
        .pend_line (pend_line),
        .isr_found (isr_found),
        .isr_line  (isr_line),
        .rdata     (rdata),
        .vector    (vector),
        .imr       (imr),
        .isr       (isr),
        .trig      (trig),
        .base      (base),
        .sfnm      (sfnm),
        .aeoi      (aeoi),
        .poll      (poll),
        .irr_clr   (irr_clr),
        .init_clr  (init_clr)
    );

    assign int_pending = pend;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Property checker for the interrupt controller, attached by bind.
module prio_irq_ctrl_chk #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             ack,
    input logic [1:0]       addr,
    input logic [LINES-1:0] wdata,
    input logic             int_pending,
    input logic [LINES-1:0] irr,
    input logic [LINES-1:0] imr,
    input logic [LINES-1:0] isr,
    input logic [LINES-1:0] trig,
    input logic             aeoi,
    input logic             sfnm,
    input logic             poll
);

    // R5: a pending output needs an unmasked request
    assert_pend_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_pending |-> ((irr & ~imr) != '0));

    // R7: initialization leaves nothing pending or in service
    assert_init_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[4]) |=> (!int_pending && isr == '0 && imr == '0));

    // R2: with no bus activity, edge-mode request bits never fall
    assert_edge_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !ack) |=> ((($past(irr) & ~trig) & ~irr) == '0));

    // R9: acknowledge under auto end-of-interrupt leaves in-service alone
    assert_aeoi_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_en && !rd_en && aeoi) |=> $stable(isr));

    // R13: poll mode lasts for one read only
    assert_poll_oneshot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && poll && !addr[1]) |=> !poll);

    // R8: a normal acknowledge adds exactly one in-service bit
    assert_ack_adds_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_en && !rd_en && int_pending && !aeoi && !sfnm)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ack         (ack),
    .addr        (addr),
    .wdata       (wdata),
    .int_pending (int_pending),
    .irr         (irr),
    .imr         (imr),
    .isr         (isr),
    .trig        (trig),
    .aeoi        (aeoi),
    .sfnm        (sfnm),
    .poll        (poll)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n, is_master, wr_en, rd_en, ack, int_pending;
    logic [7:0] irq_in, wdata, rdata, vector;
    logic [1:0] addr;

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .irq_in(irq_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .vector(vector), .int_pending(int_pending)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] lines_v = 8'h00;
    logic       master = 1'b1;

    // Reference model state
    logic [7:0] m_irr, m_prev, m_imr, m_isr, m_trig, m_vbase;
    logic [2:0] m_base;
    logic [1:0] m_ist;
    logic       m_rdsel, m_poll, m_aeoi, m_rot, m_sfnm, m_need4;

    task automatic m_reset();
        m_irr = 0; m_prev = 0; m_imr = 0; m_isr = 0; m_trig = 0; m_vbase = 0;
        m_base = 0; m_ist = 0; m_rdsel = 0; m_poll = 0; m_aeoi = 0; m_rot = 0;
        m_sfnm = 0; m_need4 = 0;
    endtask

    function automatic int f_prio(input logic [7:0] m, input logic [2:0] b);
        for (int k = 0; k < 8; k++) if (m[3'(k) + b]) return k;
        return 8;
    endfunction

    task automatic m_pend(output logic p, output logic [2:0] ln);
        int rp, cp;
        logic [7:0] cm;
        rp = f_prio(m_irr & ~m_imr, m_base);
        cm = m_isr;
        if (m_sfnm && master) cm[2] = 1'b0;
        cp = f_prio(cm, m_base);
        p  = (rp < 8) && (rp < cp);
        ln = 3'(rp) + m_base;
    endtask

    task automatic m_step(input logic w, input logic r, input logic [1:0] a,
                          input logic [7:0] d, input logic k);
        logic p;
        logic [2:0] ln, tl;
        logic [7:0] nirr, clr;
        int c;
        m_pend(p, ln);
        nirr = (m_trig & irq_in) | (~m_trig & (m_irr | (irq_in & ~m_prev)));
        m_prev = irq_in;
        clr = 0;
        if (w) begin
            if (a == 2'd0) begin
                if (d[4]) begin
                    m_imr = 0; m_isr = 0; m_vbase = 0; m_base = 0; m_rdsel = 0;
                    m_poll = 0; m_aeoi = 0; m_rot = 0; m_sfnm = 0;
                    m_need4 = d[0]; m_ist = 1; nirr = 0; m_prev = 0;
                end else if (d[3]) begin
                    if (d[2]) m_poll = 1;
                    if (d[1]) m_rdsel = d[0];
                end else begin
                    case (d[7:5])
                        3'd0, 3'd4: m_rot = d[7];
                        3'd1, 3'd5: begin
                            c = f_prio(m_isr, m_base);
                            if (c < 8) begin
                                tl = 3'(c) + m_base;
                                m_isr[tl] = 1'b0;
                                if (d[7]) m_base = tl + 3'd1;
                            end
                        end
                        3'd3: m_isr[d[2:0]] = 1'b0;
                        3'd6: m_base = d[2:0] + 3'd1;
                        3'd7: begin m_isr[d[2:0]] = 1'b0; m_base = d[2:0] + 3'd1; end
                        default: ;
                    endcase
                end
            end else if (a == 2'd1) begin
                case (m_ist)
                    2'd0: m_imr = d;
                    2'd1: begin m_vbase = d & 8'hF8; m_ist = 2; end
                    2'd2: m_ist = m_need4 ? 2'd3 : 2'd0;
                    default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_ist = 0; end
                endcase
            end else if (a == 2'd2) begin
                m_trig = d & (master ? 8'hF8 : 8'hDE);
            end
        end else if (r) begin
            if (m_poll && !a[1]) begin
                m_poll = 0;
                if (p) begin clr[ln] = 1'b1; m_isr[ln] = 1'b0; end
            end
        end else if (k && p) begin
            if (!m_trig[ln]) clr[ln] = 1'b1;
            if (m_aeoi) begin
                if (m_rot) m_base = ln + 3'd1;
            end else m_isr[ln] = 1'b1;
        end
        m_irr = nirr & ~clr;
    endtask

    task automatic check(input string tag, input string what, input logic [7:0] got,
                         input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check outputs, advance the model
    task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                       input logic [7:0] d, input logic k, input string tag);
        logic p;
        logic [2:0] ln;
        logic [7:0] er;
        @(negedge clk);
        irq_in = lines_v; is_master = master;
        wr_en = w; rd_en = r; addr = a; wdata = d; ack = k;
        #1;
        m_pend(p, ln);
        check(tag, "int_pending", {7'b0, int_pending}, {7'b0, p});
        if (r) begin
            if (m_poll && !a[1]) er = p ? {5'b0, ln} : 8'd7;
            else if (a == 2'd0) er = m_rdsel ? m_isr : m_irr;
            else if (a == 2'd1) er = m_imr;
            else if (a == 2'd2) er = m_trig;
            else er = 8'h00;
            check(tag, "rdata", rdata, er);
        end
        if (k) check(tag, "vector", vector, m_vbase | (p ? {5'b0, ln} : 8'd7));
        m_step(w, r, a, d, k);
    endtask

    task automatic idle(input string tag); cyc(0, 0, 2'd0, 8'h00, 0, tag); endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(1, 0, a, d, 0, tag);
    endtask
    task automatic rd(input logic [1:0] a, input string tag); cyc(0, 1, a, 8'h00, 0, tag); endtask
    task automatic ak(input string tag); cyc(0, 0, 2'd0, 8'h00, 1, tag); endtask
    task automatic init4(input logic [7:0] vb, input logic [7:0] mode, input string tag);
        wr(2'd0, 8'h11, tag); wr(2'd1, vb, tag); wr(2'd1, 8'h5A, tag); wr(2'd1, mode, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int op;
        logic [7:0] rv;
        void'($urandom(32'd20240611));
        rst_n = 0; is_master = 1; irq_in = 0; wr_en = 0; rd_en = 0; ack = 0;
        addr = 0; wdata = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); idle("R1");

        // R7: init with three words, then a mask load
        wr(2'd0, 8'h10, "R7"); wr(2'd1, 8'h47, "R7"); wr(2'd1, 8'h33, "R7");
        wr(2'd1, 8'hA5, "R7"); rd(2'd1, "R7"); wr(2'd1, 8'h00, "R12"); rd(2'd1, "R12");

        // R2: edge capture, held high, falling input
        lines_v = 8'h08; idle("R2"); idle("R2"); ak("R8"); idle("R2");
        wr(2'd0, 8'h20, "R10"); idle("R2"); lines_v = 8'h00; idle("R2");
        wr(2'd0, 8'h0A, "R12"); rd(2'd0, "R12");
        lines_v = 8'h20; idle("R2"); lines_v = 8'h00; idle("R2"); rd(2'd0, "R2");
        ak("R8"); wr(2'd0, 8'h20, "R10"); ak("R8");

        // R4: master write mask
        wr(2'd2, 8'hFF, "R4"); rd(2'd2, "R4");

        // R3: level line survives acknowledge
        lines_v = 8'h10; idle("R3"); ak("R3"); rd(2'd0, "R3");
        wr(2'd0, 8'h20, "R3"); lines_v = 8'h00; idle("R3"); rd(2'd0, "R3");
        wr(2'd2, 8'h00, "R4");

        // R5 / R11: rotation, nesting, specific commands
        lines_v = 8'h88; idle("R5"); ak("R5"); idle("R5");
        wr(2'd0, 8'hC3, "R11"); idle("R11"); ak("R11");
        wr(2'd0, 8'h0B, "R12"); rd(2'd0, "R12");
        wr(2'd0, 8'h20, "R10"); rd(2'd0, "R10");
        wr(2'd0, 8'h40, "R11"); rd(2'd0, "R11");
        wr(2'd0, 8'h63, "R11"); rd(2'd0, "R11");
        wr(2'd1, 8'h08, "R5"); lines_v = 8'h00; idle("R5"); lines_v = 8'h08; idle("R5");
        wr(2'd1, 8'h00, "R5"); idle("R5");

        // R10: rotating non-specific EOI; R11: specific with rotation
        lines_v = 8'h0A; idle("R10"); ak("R10"); ak("R10"); rd(2'd0, "R10");
        wr(2'd0, 8'hA0, "R10"); rd(2'd0, "R10");
        wr(2'd0, 8'hE3, "R11"); rd(2'd0, "R11"); idle("R11");

        // R13: poll with and without a pending line
        lines_v = 8'h40; idle("R13");
        wr(2'd0, 8'h0C, "R13"); rd(2'd0, "R13"); rd(2'd0, "R13");
        wr(2'd0, 8'h0C, "R13"); rd(2'd1, "R13"); rd(2'd1, "R13");

        // R9: auto EOI with rotation
        lines_v = 8'h00; init4(8'h40, 8'h02, "R9"); wr(2'd0, 8'h80, "R9");
        lines_v = 8'h04; idle("R9"); ak("R9"); rd(2'd0, "R9");
        lines_v = 8'h00; idle("R9"); lines_v = 8'h44; idle("R9"); ak("R9"); ak("R9");

        // R6: special nesting on line 2, then as slave
        lines_v = 8'h00; init4(8'h48, 8'h10, "R6");
        lines_v = 8'h04; idle("R6"); ak("R6"); lines_v = 8'h00; idle("R6");
        lines_v = 8'h04; idle("R6"); idle("R6");
        master = 1'b0; idle("R6"); wr(2'd2, 8'hFF, "R4"); rd(2'd2, "R4");
        master = 1'b1; idle("R6"); ak("R6");

        // Random traffic checked against the model
        lines_v = 8'h00; wr(2'd0, 8'h10, "R7"); wr(2'd1, 8'h80, "R7"); wr(2'd1, 8'h00, "R7");
        for (int i = 0; i < 3000; i++) begin
            op = $urandom_range(0, 99);
            rv = 8'($urandom);
            if (op < 25) begin
                lines_v = lines_v ^ (8'h01 << rv[2:0]); idle("R2");
            end else if (op < 42) ak("R8");
            else if (op < 50) wr(2'd1, rv & 8'h3C, "R5");
            else if (op < 64) wr(2'd0, {rv[7:5], 2'b00, rv[2:0]}, "R11");
            else if (op < 73) wr(2'd0, {1'b0, rv[6:5], 2'b01, rv[2:0]}, "R12");
            else if (op < 88) rd(2'(rv[1:0]), "R13");
            else if (op < 93) wr(2'd2, rv, "R4");
            else if (op < 95) wr(2'd0, {3'b000, 1'b1, 3'b000, rv[0]}, "R7");
            else idle("R5");
        end
        idle("R5");
        summary();
        $finish;
    end

endmodule